// File: doc/BRIEF.md
# Per-Line Trigger-Mode Interrupt Request Capture

This block samples a vector of interrupt input lines once per clock and holds one pending-request bit per line. Each line is either edge-sensitive or level-sensitive. A trigger-select register chooses the mode, and a per-line "seen high" bit supports edge detection. A level-sensitive request follows its input. An edge-sensitive request is set only on a low-to-high transition and stays set until the line drops or the request is acknowledged.

A downstream arbiter reads the request vector and acknowledges one line at a time by index. An acknowledge clears only edge-mode requests, because a level-mode request stays set for as long as its input is held. Software can write the trigger-select register. A per-instance constant mask fixes some lines permanently in edge mode. A reinitialise strobe drops every pending request and every remembered level, and leaves the trigger mode as it was.

Top module: `trig_capture`

## Requirements
- R1: After synchronous reset, `req_out` is all zeros and `tsel_rdata` is all zeros.
- R2: A write (`tsel_wr`=1) stores `tsel_wdata & TSEL_WMASK`, which appears on `tsel_rdata` after the next clock edge. Without a write, the stored value does not change.
- R3: For a line whose trigger-select bit is 1 (level mode), the request bit after a clock edge equals the input level sampled at that edge.
- R4: For a line whose trigger-select bit is 0 (edge mode), a high input sets the request only if the line's remembered level was low. Holding the input high after an acknowledge does not set the request again.
- R5: In edge mode, a low input clears both the request and the remembered level at the next edge.
- R6: An acknowledge (`ack_stb`=1, `ack_idx`=n, binary line number) clears request n at the next edge if line n is in edge mode. It leaves request n unchanged in level mode.
- R7: When an edge-mode line sees a rising level and is acknowledged in the same cycle, the acknowledge is applied after the level update, and the request is 0 after the edge.
- R8: `reinit` clears every request and every remembered level at the next edge and leaves the trigger-select register unchanged. A line that is still held high in edge mode then triggers again one cycle later.
- R9: An acknowledge affects only the line that `ack_idx` names. The requests of all other lines follow their own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lines_in | input | NUM_LINES | Synchronous interrupt input levels |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_idx | input | clog2(NUM_LINES) | Line number being acknowledged |
| tsel_wr | input | 1 | Trigger-select write enable |
| tsel_wdata | input | NUM_LINES | Trigger-select write data, 1 = level mode |
| reinit | input | 1 | Clears requests and remembered levels |
| req_out | output | NUM_LINES | Pending-request vector |
| tsel_rdata | output | NUM_LINES | Stored trigger-select value |

## Verification
The assertions assume that `lines_in` is already synchronous to `clk`, so each edge sees one settled level per line. They also assume that `ack_idx` is below `NUM_LINES` whenever `ack_stb` is high. The stimulus changes every input only on the falling clock edge and draws `ack_idx` from the legal range. Random mixes of acknowledges, writes and reinitialise strobes keep the one-line-at-a-time acknowledge property exercised, and the mode of every checked line stays defined.

// File: rtl/trigcap_pkg.sv
package trigcap_pkg;

    localparam int unsigned DEF_LINES = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic req;   // pending request
        logic seen;  // level remembered for edge detection
    } line_state_t;

    // Next state of one line: level update first, acknowledge clear last.
    function automatic line_state_t line_next(
        input line_state_t cur,
        input trig_mode_e  mode,
        input logic        level,
        input logic        ack_hit
    );
        line_state_t nxt;
        if (mode == TRIG_LEVEL) begin
            nxt.req  = level;
            nxt.seen = level;
        end else if (level) begin
            nxt.req  = cur.req | ~cur.seen;
            nxt.seen = 1'b1;
        end else begin
            nxt.req  = 1'b0;
            nxt.seen = 1'b0;
        end
        if (ack_hit && mode == TRIG_EDGE) begin
            nxt.req = 1'b0;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/trigcap_sel_reg.sv
module trigcap_sel_reg #(
    parameter int unsigned     W     = 8,
    parameter logic [W-1:0]    WMASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value
);

    logic [W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (wr) begin
            sel_q <= wdata & WMASK;
        end
    end

    assign value = sel_q;

    // R2: a write lands masked on the next edge
    a_r2_masked_write: assert property (@(posedge clk) disable iff (rst)
        wr |=> (value == ($past(wdata) & WMASK)));

    // R2 / R8: without a write the register holds
    a_r8_sel_hold: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(value));

endmodule

// File: rtl/trigcap_ack_decode.sv
module trigcap_ack_decode #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          stb,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  hit
);

    always_comb begin
        hit = '0;
        for (int i = 0; i < N; i++) begin
            if (stb && (int'(idx) == i)) begin
                hit[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/trigcap_line.sv
module trigcap_line
    import trigcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reinit,
    input  logic       level,
    input  trig_mode_e mode,
    input  logic       ack_hit,
    output logic       req
);

    line_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst || reinit) begin
            st_q <= '0;
        end else begin
            st_q <= line_next(st_q, mode, level, ack_hit);
        end
    end

    assign req = st_q.req;

    // R3: level mode request tracks the sampled input
    a_r3_level_follow: assert property (@(posedge clk) disable iff (rst)
        (!reinit && mode == TRIG_LEVEL) |=> (req == $past(level)));

    // R5: low input in edge mode drops the request
    a_r5_edge_low: assert property (@(posedge clk) disable iff (rst)
        (!reinit && mode == TRIG_EDGE && !level) |=> !req);

    // R6 / R7: acknowledge of an edge line always leaves it clear
    a_r6_ack_edge: assert property (@(posedge clk) disable iff (rst)
        (ack_hit && mode == TRIG_EDGE) |=> !req);

    // R4: an edge-mode request cannot appear while the line stays high and was already seen
    a_r4_no_retrigger: assert property (@(posedge clk) disable iff (rst)
        (!reinit && mode == TRIG_EDGE && level && !req && $past(level)
         && $past(mode) == TRIG_EDGE && !$past(reinit) && !$past(rst)
         && $past(ack_hit)) |=> !req);

    // R8: reinitialise clears the request
    a_r8_reinit_clear: assert property (@(posedge clk) disable iff (rst)
        reinit |=> !req);

endmodule

// File: rtl/trig_capture.sv
module trig_capture
    import trigcap_pkg::*;
#(
    parameter int unsigned               NUM_LINES  = DEF_LINES,
    parameter logic [NUM_LINES-1:0]      TSEL_WMASK = 8'hDE
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_LINES-1:0]           lines_in,
    input  logic                           ack_stb,
    input  logic [$clog2(NUM_LINES)-1:0]   ack_idx,
    input  logic                           tsel_wr,
    input  logic [NUM_LINES-1:0]           tsel_wdata,
    input  logic                           reinit,
    output logic [NUM_LINES-1:0]           req_out,
    output logic [NUM_LINES-1:0]           tsel_rdata
);

    localparam int unsigned IDX_W = $clog2(NUM_LINES);

    logic [NUM_LINES-1:0] tsel;
    logic [NUM_LINES-1:0] ack_hit;

    trigcap_sel_reg #(
        .W     (NUM_LINES),
        .WMASK (TSEL_WMASK)
    ) u_sel (
        .clk   (clk),
        .rst   (rst),
        .wr    (tsel_wr),
        .wdata (tsel_wdata),
        .value (tsel)
    );

    trigcap_ack_decode #(
        .N  (NUM_LINES),
        .IW (IDX_W)
    ) u_ack (
        .stb (ack_stb),
        .idx (ack_idx),
        .hit (ack_hit)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        trigcap_line u_line (
            .clk     (clk),
            .rst     (rst),
            .reinit  (reinit),
            .level   (lines_in[g]),
            .mode    (trig_mode_e'(tsel[g])),
            .ack_hit (ack_hit[g]),
            .req     (req_out[g])
        );
    end

    assign tsel_rdata = tsel;

    // R9: the decoder never names more than one line
    a_r9_single_ack: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_hit));

    // R9: a silent strobe hits no line
    a_r9_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
        !ack_stb |-> (ack_hit == '0));

    // R1: one cycle after reset everything reads zero
    a_r1_reset_zero: assert property (@(posedge clk)
        $past(rst) |-> (req_out == '0 && tsel_rdata == '0));

endmodule

// File: tb/tb_trig_capture.sv
module tb_trig_capture;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned N          = 8;
    localparam logic [N-1:0] MASK      = 8'hDE;
    localparam int unsigned WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] lines_in;
    logic         ack_stb;
    logic [2:0]   ack_idx;
    logic         tsel_wr;
    logic [N-1:0] tsel_wdata;
    logic         reinit;
    logic [N-1:0] req_out;
    logic [N-1:0] tsel_rdata;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 0;

    logic [N-1:0] m_req, m_seen, m_tsel;

    trig_capture #(.NUM_LINES(N), .TSEL_WMASK(MASK)) dut (
        .clk(clk), .rst(rst), .lines_in(lines_in), .ack_stb(ack_stb),
        .ack_idx(ack_idx), .tsel_wr(tsel_wr), .tsel_wdata(tsel_wdata),
        .reinit(reinit), .req_out(req_out), .tsel_rdata(tsel_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model, written from the requirements
    task automatic model_update();
        logic [N-1:0] nr, ns;
        if (rst) begin
            m_req = '0; m_seen = '0; m_tsel = '0;
            return;
        end
        for (int i = 0; i < N; i++) begin
            if (m_tsel[i]) begin
                nr[i] = lines_in[i]; ns[i] = lines_in[i];
            end else if (lines_in[i]) begin
                nr[i] = m_req[i] | ~m_seen[i]; ns[i] = 1'b1;
            end else begin
                nr[i] = 1'b0; ns[i] = 1'b0;
            end
            if (ack_stb && int'(ack_idx) == i && !m_tsel[i]) nr[i] = 1'b0;
        end
        if (reinit) begin
            nr = '0; ns = '0;
        end
        m_req  = nr;
        m_seen = ns;
        if (tsel_wr) m_tsel = tsel_wdata & MASK;
    endtask

    // One clock: inputs already set (at the falling edge), compare after the rising edge
    task automatic step(input bit compare);
        model_update();
        @(posedge clk);
        #1;
        if (compare) begin
            chk("model R3 R4 R5 R6 R8 req", {24'd0, req_out}, {24'd0, m_req});
            chk("model R2 tsel", {24'd0, tsel_rdata}, {24'd0, m_tsel});
        end
        @(negedge clk);
        ack_stb = 0; tsel_wr = 0; reinit = 0;
    endtask

    task automatic idle_inputs();
        lines_in = '0; ack_stb = 0; ack_idx = '0;
        tsel_wr = 0; tsel_wdata = '0; reinit = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        idle_inputs();
        rst = 1;
        m_req = '0; m_seen = '0; m_tsel = '0;
        @(negedge clk);
        step(0); step(0); step(0);
        rst = 0;
        // R1: reset state
        chk("R1 req after reset", {24'd0, req_out}, 32'd0);
        chk("R1 tsel after reset", {24'd0, tsel_rdata}, 32'd0);

        // R2: masked write
        tsel_wr = 1; tsel_wdata = 8'hFF;
        step(1);
        chk("R2 masked tsel", {24'd0, tsel_rdata}, {24'd0, MASK});

        // R3 / R6: line 1 is level mode (bit 1 of mask is 1)
        lines_in = 8'h02; step(1);
        chk("R3 level high sets", {31'd0, req_out[1]}, 32'd1);
        ack_stb = 1; ack_idx = 3'd1; step(1);
        chk("R6 level ack keeps", {31'd0, req_out[1]}, 32'd1);
        lines_in = 8'h00; step(1);
        chk("R3 level low clears", {31'd0, req_out[1]}, 32'd0);

        // R4 / R5 / R6: line 0 is always edge mode
        lines_in = 8'h01; step(1);
        chk("R4 edge rise sets", {31'd0, req_out[0]}, 32'd1);
        ack_stb = 1; ack_idx = 3'd0; step(1);
        chk("R6 edge ack clears", {31'd0, req_out[0]}, 32'd0);
        step(1); step(1);
        chk("R4 held high no retrigger", {31'd0, req_out[0]}, 32'd0);
        lines_in = 8'h00; step(1);
        lines_in = 8'h01; step(1);
        chk("R4 second rise sets", {31'd0, req_out[0]}, 32'd1);
        lines_in = 8'h00; step(1);
        chk("R5 edge low clears", {31'd0, req_out[0]}, 32'd0);

        // R7: rise and acknowledge in the same cycle
        lines_in = 8'h01; ack_stb = 1; ack_idx = 3'd0; step(1);
        chk("R7 ack after update", {31'd0, req_out[0]}, 32'd0);

        // R9: acknowledge on line 0 leaves line 5 (edge) pending
        lines_in = 8'h21; step(1);
        ack_stb = 1; ack_idx = 3'd0; step(1);
        chk("R9 other line untouched", {31'd0, req_out[5]}, 32'd1);

        // R8: reinitialise
        lines_in = 8'h00; step(1);
        lines_in = 8'h03; step(1);
        chk("R8 pre-reinit pending", {30'd0, req_out[1:0]}, 32'd3);
        reinit = 1; step(1);
        chk("R8 reinit clears req", {24'd0, req_out}, 32'd0);
        chk("R8 reinit keeps tsel", {24'd0, tsel_rdata}, {24'd0, MASK});
        step(1);
        chk("R8 edge retriggers after reinit", {30'd0, req_out[1:0]}, 32'd3);

        // Random phase
        for (int k = 0; k < 2000; k++) begin
            lines_in   = N'($urandom);
            ack_stb    = ($urandom % 3) == 0;
            ack_idx    = 3'($urandom % N);
            tsel_wr    = ($urandom % 16) == 0;
            tsel_wdata = N'($urandom);
            reinit     = ($urandom % 40) == 0;
            step(1);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule